// File: doc/BRIEF.md
# Ethernet Transmit Frame Serializer

This block turns byte-wide frame data into the serial non-return-to-zero bit stream that a line encoder expects, at one bit per clock. When a start request arrives it sends seven bytes of an alternating pattern, then the start-of-frame delimiter. It then reads payload bytes one at a time from a first-word-fall-through FIFO and shifts each one out. When the FIFO marks a byte as the last one, the block ends the frame. By default it appends a 32-bit frame check sequence. A latched inhibit bit suppresses that sequence, so that a frame which already carries one can be forwarded unchanged.

A collision input cuts a frame short and replaces what remains with 32 one-bits. Collisions seen during the preamble or delimiter are remembered and acted on only after bit 64. Every collision fragment is therefore at least 96 bits long. If the FIFO runs dry before the end-of-frame byte, the frame is abandoned without a check sequence and an underrun is reported.

The controller has six named states:
- IDLE → PRE on a start request.
- PRE → SFD after the last preamble byte.
- SFD → JAM when a collision is current or pending.
- SFD → IDLE on underrun.
- SFD → DATA otherwise.
- DATA → JAM on a collision.
- DATA → FCS at the end-of-frame byte when the check sequence is enabled.
- DATA → IDLE at the end-of-frame byte when the check sequence is inhibited (done).
- DATA → IDLE on underrun.
- DATA → DATA for the next byte.
- FCS → JAM on a collision.
- FCS → IDLE after 32 bits (done).
- JAM → IDLE after the jam (collision status).

Top module: `eth_tx_serializer`

## Requirements
- R1: After reset, `tx_en_o`, `txd_o`, `fifo_rd_o` and all three status outputs are low. While `tx_en_o` is low, `txd_o` is low.
- R2: A start request seen in IDLE makes `tx_en_o` high from the next cycle. The first 64 bits are seven bytes 0x55 and then the delimiter byte 0xD5, each byte sent least significant bit first. On the wire this reads 1010…10101011.
- R3: Payload bytes follow the delimiter with no gap, least significant bit first. `fifo_rd_o` is high only when the FIFO is not empty, and it is high in the cycle that carries the final bit of the preceding byte. Every byte of a completed frame is consumed.
- R4: Unless inhibited, the 32 bits after the last payload bit are the check sequence. It is a CRC-32 with reflected polynomial 0xEDB88320, preset to all ones and computed over the payload bits. The complement of the register is sent least significant bit first.
- R5: When `crc_inhibit_i` is high at the start request, the frame ends right after the last payload bit, with no check sequence.
- R6: A collision seen during payload or check-sequence bit k leaves bits 0..k unchanged. Bits k+1 to k+32 are ones, and then `tx_en_o` falls.
- R7: A collision seen during any of the first 64 bits does not shorten them. Exactly 64 preamble and delimiter bits are sent, then 32 ones.
- R8: In the first cycle after `tx_en_o` falls, exactly one status output is high for one cycle. `done_o` marks a normal end and `coll_done_o` marks the end of a jam.
- R9: If the FIFO is empty when a payload byte is due and the current byte is not the end-of-frame byte, `tx_en_o` falls after that byte's last bit and `underrun_o` pulses. No check sequence or jam is sent.
- R10: A collision in IDLE has no effect. A start request while a frame is in progress is ignored and does not alter the bit stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a frame (used in IDLE) |
| crc_inhibit_i | input | 1 | Suppress the check sequence; latched at start |
| coll_i | input | 1 | Collision detected on the medium |
| fifo_empty_i | input | 1 | FIFO holds no byte |
| fifo_data_i | input | 8 | Byte at the FIFO head |
| fifo_eof_i | input | 1 | Head byte is the last byte of the frame |
| fifo_rd_o | output | 1 | Pop the FIFO head |
| txd_o | output | 1 | Serial NRZ data |
| tx_en_o | output | 1 | Frame bits are valid on `txd_o` |
| done_o | output | 1 | One-cycle pulse: frame completed |
| coll_done_o | output | 1 | One-cycle pulse: jam completed |
| underrun_o | output | 1 | One-cycle pulse: frame abandoned on an empty FIFO |

## Verification
The bench builds the block with its default parameters: seven preamble bytes and a four-byte jam. This gives the 96-bit minimum fragment that the collision cases check. Collisions are placed at bit 20, at the final delimiter bit 63, in the payload and inside the check sequence. This covers both the deferred path and the immediate path into the jam. Short frames with and without the check sequence, an underrun at the delimiter and one mid-payload, and an idle collision cover every state transition.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_DATA,
        ST_FCS,
        ST_JAM
    } txs_state_e;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned FCS_W  = 32;
endpackage

// File: rtl/txs_crc32.sv
module txs_crc32 #(
    parameter logic [31:0] POLY = 32'hEDB88320
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic        din,
    output logic [31:0] crc_nxt
);
    logic [31:0] crc_q;

    // one serial step of the reflected division
    always_comb begin
        crc_nxt = {1'b0, crc_q[31:1]} ^ ((crc_q[0] ^ din) ? POLY : 32'h0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= '1;
        else if (init) crc_q <= '1;
        else if (en)   crc_q <= crc_nxt;
    end
endmodule

// File: rtl/txs_shifter.sv
module txs_shifter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         sout
);
    logic [W-1:0] sh_q;

    // ones fill from the top so a loaded all-ones word stays all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= din;
        else if (shift) sh_q <= {1'b1, sh_q[W-1:1]};
    end

    assign sout = sh_q[0];
endmodule

// File: rtl/eth_tx_serializer.sv
module eth_tx_serializer
    import eth_tx_pkg::*;
#(
    parameter int unsigned     PRE_BYTES = 7,
    parameter int unsigned     JAM_BYTES = 4,
    parameter logic [7:0]      PRE_PAT   = 8'h55,
    parameter logic [7:0]      SFD_PAT   = 8'hD5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       crc_inhibit_i,
    input  logic       coll_i,
    input  logic       fifo_empty_i,
    input  logic [7:0] fifo_data_i,
    input  logic       fifo_eof_i,
    output logic       fifo_rd_o,
    output logic       txd_o,
    output logic       tx_en_o,
    output logic       done_o,
    output logic       coll_done_o,
    output logic       underrun_o
);
    localparam int unsigned JAM_BITS = JAM_BYTES * BYTE_W;
    localparam int unsigned LONG_MAX = (JAM_BITS > FCS_W) ? JAM_BITS : FCS_W;
    localparam int unsigned CNT_W    = $clog2(LONG_MAX);
    localparam int unsigned PCNT_W   = $clog2(PRE_BYTES + 1);
    localparam int unsigned SH_W     = (JAM_BITS > FCS_W) ? JAM_BITS : FCS_W;

    txs_state_e state, state_n;

    logic [CNT_W-1:0]  bitcnt;
    logic [PCNT_W-1:0] precnt;
    logic              coll_pend, inh_q, eof_q;

    logic              sh_load, sh_out;
    logic [SH_W-1:0]   sh_val;
    logic              cnt_clr, pre_inc, crc_init, crc_en;
    logic              fin_done, fin_coll, fin_und;
    logic [31:0]       crc_nxt;
    logic              last8, last_fcs, last_jam;

    assign last8    = (bitcnt == CNT_W'(BYTE_W - 1));
    assign last_fcs = (bitcnt == CNT_W'(FCS_W - 1));
    assign last_jam = (bitcnt == CNT_W'(JAM_BITS - 1));

    txs_shifter #(.W(SH_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .shift (state != ST_IDLE),
        .din   (sh_val),
        .sout  (sh_out)
    );

    txs_crc32 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (crc_init),
        .en      (crc_en),
        .din     (sh_out),
        .crc_nxt (crc_nxt)
    );

    assign tx_en_o = (state != ST_IDLE);
    assign txd_o   = tx_en_o & sh_out;

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bitcnt      <= '0;
            precnt      <= '0;
            coll_pend   <= 1'b0;
            inh_q       <= 1'b0;
            eof_q       <= 1'b0;
            done_o      <= 1'b0;
            coll_done_o <= 1'b0;
            underrun_o  <= 1'b0;
        end else begin
            state       <= state_n;
            done_o      <= fin_done;
            coll_done_o <= fin_coll;
            underrun_o  <= fin_und;
            if (cnt_clr)                bitcnt <= '0;
            else if (state != ST_IDLE)  bitcnt <= bitcnt + 1'b1;
            if (state == ST_IDLE && start_i) begin
                precnt    <= '0;
                coll_pend <= 1'b0;
                inh_q     <= crc_inhibit_i;
            end else begin
                if (pre_inc) precnt <= precnt + 1'b1;
                if ((state == ST_PRE || state == ST_SFD) && coll_i) coll_pend <= 1'b1;
            end
            if (fifo_rd_o) eof_q <= fifo_eof_i;
        end
    end

    // next state and control outputs
    always_comb begin
        state_n   = state;
        sh_load   = 1'b0;
        sh_val    = '0;
        cnt_clr   = 1'b0;
        pre_inc   = 1'b0;
        crc_init  = 1'b0;
        crc_en    = 1'b0;
        fifo_rd_o = 1'b0;
        fin_done  = 1'b0;
        fin_coll  = 1'b0;
        fin_und   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    state_n  = ST_PRE;
                    sh_load  = 1'b1;
                    sh_val   = SH_W'(PRE_PAT);
                    cnt_clr  = 1'b1;
                    crc_init = 1'b1;
                end
            end
            ST_PRE: begin
                if (last8) begin
                    cnt_clr = 1'b1;
                    sh_load = 1'b1;
                    pre_inc = 1'b1;
                    if (precnt == PCNT_W'(PRE_BYTES - 1)) begin
                        state_n = ST_SFD;
                        sh_val  = SH_W'(SFD_PAT);
                    end else begin
                        sh_val  = SH_W'(PRE_PAT);
                    end
                end
            end
            ST_SFD: begin
                if (last8) begin
                    cnt_clr = 1'b1;
                    if (coll_i || coll_pend) begin
                        state_n = ST_JAM;
                        sh_load = 1'b1;
                        sh_val  = '1;
                    end else if (fifo_empty_i) begin
                        state_n = ST_IDLE;
                        fin_und = 1'b1;
                    end else begin
                        state_n   = ST_DATA;
                        sh_load   = 1'b1;
                        sh_val    = SH_W'(fifo_data_i);
                        fifo_rd_o = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                crc_en = 1'b1;
                if (coll_i) begin
                    state_n = ST_JAM;
                    sh_load = 1'b1;
                    sh_val  = '1;
                    cnt_clr = 1'b1;
                end else if (last8) begin
                    cnt_clr = 1'b1;
                    if (eof_q) begin
                        if (inh_q) begin
                            state_n  = ST_IDLE;
                            fin_done = 1'b1;
                        end else begin
                            state_n = ST_FCS;
                            sh_load = 1'b1;
                            sh_val  = SH_W'(~crc_nxt);
                        end
                    end else if (fifo_empty_i) begin
                        state_n = ST_IDLE;
                        fin_und = 1'b1;
                    end else begin
                        sh_load   = 1'b1;
                        sh_val    = SH_W'(fifo_data_i);
                        fifo_rd_o = 1'b1;
                    end
                end
            end
            ST_FCS: begin
                if (coll_i) begin
                    state_n = ST_JAM;
                    sh_load = 1'b1;
                    sh_val  = '1;
                    cnt_clr = 1'b1;
                end else if (last_fcs) begin
                    state_n  = ST_IDLE;
                    fin_done = 1'b1;
                end
            end
            ST_JAM: begin
                if (last_jam) begin
                    state_n  = ST_IDLE;
                    fin_coll = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !tx_en_o |-> !txd_o); // R1
    AST_RD_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n) fifo_rd_o |-> !fifo_empty_i); // R3
    AST_INH_NO_FCS: assert property (@(posedge clk) disable iff (!rst_n) inh_q |-> state != ST_FCS); // R5
    AST_JAM_ONES: assert property (@(posedge clk) disable iff (!rst_n) state == ST_JAM |-> txd_o); // R6
    AST_PRE_NO_JAM: assert property (@(posedge clk) disable iff (!rst_n) state == ST_PRE |=> state != ST_JAM); // R7
    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done_o, coll_done_o, underrun_o})); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R8
    AST_IDLE_COLL: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_IDLE && !start_i) |=> !tx_en_o); // R10
endmodule

// File: tb/eth_tx_serializer_bench.sv
module eth_tx_serializer_bench;
    localparam time CLK_P = 5ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, crc_inhibit_i = 1'b0, coll_i = 1'b0;
    logic       fifo_empty_i = 1'b1, fifo_eof_i = 1'b0;
    logic [7:0] fifo_data_i = 8'h00;
    logic       fifo_rd_o, txd_o, tx_en_o, done_o, coll_done_o, underrun_o;

    int n_chk = 0, n_fail = 0;
    logic [7:0] fq_d[$];
    bit         fq_e[$];
    bit         pop_pend = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    eth_tx_serializer u_eth_tx_serializer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .crc_inhibit_i(crc_inhibit_i),
        .coll_i(coll_i), .fifo_empty_i(fifo_empty_i), .fifo_data_i(fifo_data_i),
        .fifo_eof_i(fifo_eof_i), .fifo_rd_o(fifo_rd_o), .txd_o(txd_o), .tx_en_o(tx_en_o),
        .done_o(done_o), .coll_done_o(coll_done_o), .underrun_o(underrun_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fifo_drive();
        fifo_empty_i = (fq_d.size() == 0);
        fifo_data_i  = fifo_empty_i ? 8'h00 : fq_d[0];
        fifo_eof_i   = fifo_empty_i ? 1'b0 : fq_e[0];
    endtask

    // one clock: pop what the last edge consumed, then let outputs settle
    task automatic tick();
        @(negedge clk);
        if (pop_pend && fq_d.size() > 0) begin
            void'(fq_d.pop_front());
            void'(fq_e.pop_front());
        end
        fifo_drive();
        #1;
        pop_pend = fifo_rd_o;
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c, input bit d);
        logic fb;
        fb = c[0] ^ d;
        c  = c >> 1;
        if (fb) c ^= 32'hEDB88320;
        return c;
    endfunction

    // kind: 0 done, 1 collision, 2 underrun
    task automatic run_frame(input int nbytes, input logic [7:0] seed, input bit eof,
                             input bit inh, input int coll_at, input int restart_at, input string req);
        bit exp[$];
        logic [31:0] crc;
        logic [7:0] b;
        int kind, cut;
        crc = '1;
        for (int i = 0; i < 7; i++) for (int k = 0; k < 8; k++) exp.push_back(1'((8'h55 >> k) & 1));
        for (int k = 0; k < 8; k++) exp.push_back(1'((8'hD5 >> k) & 1));
        fq_d.delete(); fq_e.delete();
        for (int i = 0; i < nbytes; i++) begin
            b = seed + 8'(37 * i);
            fq_d.push_back(b);
            fq_e.push_back(eof && (i == nbytes - 1));
            for (int k = 0; k < 8; k++) begin
                exp.push_back(b[k]);
                crc = crc_step(crc, b[k]);
            end
        end
        if (eof) begin
            kind = 0;
            if (!inh) for (int k = 0; k < 32; k++) exp.push_back(~crc[k]);
        end else kind = 2;
        if (kind == 0 && coll_at >= 0 && coll_at < exp.size()) begin
            cut = (coll_at < 64) ? 64 : coll_at + 1;
            while (exp.size() > cut) void'(exp.pop_back());
            for (int k = 0; k < 32; k++) exp.push_back(1'b1);
            kind = 1;
        end
        @(negedge clk);
        fifo_drive();
        crc_inhibit_i = inh;
        start_i = 1'b1;
        for (int i = 0; i < exp.size(); i++) begin
            tick();
            start_i = (i == restart_at);
            coll_i  = (i == coll_at);
            chk(tx_en_o == 1'b1, req, $sformatf("tx_en bit %0d", i), tx_en_o, 1);
            chk(txd_o == exp[i], req, $sformatf("txd bit %0d", i), txd_o, exp[i]);
        end
        tick();
        start_i = 1'b0;
        coll_i  = 1'b0;
        chk(tx_en_o == 1'b0, "R8", {req, " tx_en after end"}, tx_en_o, 0);
        chk(done_o == (kind == 0), "R8", {req, " done pulse"}, done_o, kind == 0);
        chk(coll_done_o == (kind == 1), "R8", {req, " coll pulse"}, coll_done_o, kind == 1);
        chk(underrun_o == (kind == 2), "R9", {req, " underrun pulse"}, underrun_o, kind == 2);
        if (kind == 0) chk(fq_d.size() == 0, "R3", {req, " fifo drained"}, fq_d.size(), 0);
        tick();
        chk({done_o, coll_done_o, underrun_o} == 3'b000, "R8", {req, " pulse one cycle"},
            {done_o, coll_done_o, underrun_o}, 0);
        chk(tx_en_o == 1'b0, "R10", {req, " stays idle"}, tx_en_o, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(tx_en_o == 0 && txd_o == 0, "R1", "outputs in reset", {tx_en_o, txd_o}, 0);
        chk({done_o, coll_done_o, underrun_o, fifo_rd_o} == 0, "R1", "status in reset",
            {done_o, coll_done_o, underrun_o, fifo_rd_o}, 0);
        rst_n = 1'b1;
        tick(); tick();
        chk(tx_en_o == 0, "R1", "idle after reset", tx_en_o, 0);
        // idle collision has no effect
        coll_i = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk(tx_en_o == 0 && coll_done_o == 0, "R10", "idle collision", {tx_en_o, coll_done_o}, 0);
        end
        coll_i = 1'b0;
        tick();
        run_frame(4, 8'h3C, 1, 0, -1, -1, "R4");   // normal frame with FCS (R2 R3)
        run_frame(1, 8'hA7, 1, 1, -1, -1, "R5");   // inhibited FCS
        run_frame(6, 8'h11, 1, 0, 20, -1, "R7");   // collision in preamble
        run_frame(6, 8'h42, 1, 0, 63, -1, "R7");   // collision on last delimiter bit
        run_frame(6, 8'h90, 1, 0, 70, -1, "R6");   // collision in payload
        run_frame(2, 8'hF0, 1, 0, 95, -1, "R6");   // collision in FCS
        run_frame(3, 8'h5A, 0, 0, -1, -1, "R9");   // underrun mid payload
        run_frame(0, 8'h00, 0, 0, -1, -1, "R9");   // underrun at delimiter
        run_frame(5, 8'hC3, 1, 0, -1, 30, "R10");  // restart request while busy
        run_frame(3, 8'h01, 1, 0, -1, -1, "R2");   // back-to-back frame
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule